// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers interrupt requests from a parameterised number of sources, up to 256. For each source it holds a pending flag, an enable bit and a 5-bit priority. Every cycle it chooses one source from those that are pending, enabled and at a nonzero priority level. It registers the number of that source as a vector, drives an interrupt request to the processor, and shows the vector and its priority in a status word.

Each source is one of two kinds:

- **Persistent (level):** the flag follows an asserted request and cannot be cleared while the request is still high.
- **Non-persistent (edge):** the flag is captured on an edge and stays set until software clears it.

The lowest-numbered sources are fed by external pins. Each pin has a polarity bit that selects rising-edge or falling-edge detection.

Software reaches the state through a 32-bit register bus. Control, flag, enable and priority words each have three addresses:

- the plain address replaces the word;
- plain+0x4 clears the bits written as 1;
- plain+0x8 sets the bits written as 1.

Next to these sits a per-source table of 32-bit vector offset words that the controller only stores.

Top module: `vpic_top`

## Requirements
- R1: After reset, every flag, enable, priority, polarity bit and vector offset word reads zero, the status word reads zero and `irq_o` is low.
- R2: For control, flag, enable and priority words, a write to the plain address replaces the word, a write to plain+0x4 clears only the bits written as 1, and a write to plain+0x8 sets only the bits written as 1. Enable word n is at 0x0C0+n*0x10 and flag word n is at 0x040+n*0x10, with source k at bit k%32 of word k/32.
- R3: An edge source sets its flag on a rising request edge. The flag stays set after the request drops, until a clear alias write removes it. A request that is held high does not set the flag again.
- R4: A level source keeps its flag set while its request is high, and a clear written in that time has no effect. A clear written after the request has dropped removes the flag.
- R5: External pin j feeds source j and has its polarity in control bit j+1 at 0x000. With that bit at 1 the pin flags on a rising edge; with it at 0 the pin flags on a falling edge. The opposite edge never sets the flag.
- R6: Source k has its priority in bits [4:0] of byte lane k%4 of the priority word at 0x140+(k/4)*0x10. Bits [4:2] are the major level and bits [1:0] are the sub-level. Bits [7:5] of each lane read zero.
- R7: Among pending, enabled sources with a nonzero major level, the winner has the highest major level, then the highest sub-level, then the lowest source number. Sources at major level 0 are never chosen.
- R8: The status word at 0x020 carries the winning source number in bits [7:0] and its 5-bit priority in bits [12:8]. It reads zero when nothing qualifies. `irq_o` is high exactly when a winner exists. Both outputs are registered: they reflect the flag, enable and priority state one clock earlier.
- R9: A source whose flag is set but whose enable bit is clear is not selected.
- R10: The vector offset word for source k is at 0x540+k*4. A plain write stores all 32 bits, which read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address of register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| src_i | input | N_SRC-N_EXT | Peripheral requests; bit i feeds source i+N_EXT |
| ext_i | input | N_EXT | External pins, feeding sources 0..N_EXT-1 |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Number of the selected source |

## Verification
The hardest case to reach is a clear written to a level source while its request is still asserted. The flag must survive that write and must drop only on a later clear, after the request has gone low. The bench holds the request line high across a clear-alias write, then checks both the flag word and the still-asserted `irq_o`. Only then does it release the line and clear again. Arbitration ties are also awkward to produce: the bench pulses three edge sources in the same cycle, then rewrites one priority lane so that two sources reach an exact tie and the lower number has to win.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  // 16-byte slot numbers (addr[11:4]) of the register regions
  localparam logic [7:0]  SLOT_CTL  = 8'h00;
  localparam logic [7:0]  SLOT_STAT = 8'h02;
  localparam logic [7:0]  SLOT_FLAG = 8'h04;
  localparam logic [7:0]  SLOT_EN   = 8'h0C;
  localparam logic [7:0]  SLOT_PRI  = 8'h14;
  localparam logic [11:0] VOFS_BASE = 12'h540;
  localparam int          PRI_W     = 5;

  function automatic logic [31:0] apply_op(logic [31:0] old, logic [31:0] wd, wr_op_e op);
    case (op)
      OP_PLAIN: return wd;
      OP_CLR:   return old & ~wd;
      OP_SET:   return old | wd;
      default:  return old;
    endcase
  endfunction

  function automatic logic [PRI_W-1:0] apply_pri(logic [PRI_W-1:0] old, logic [PRI_W-1:0] wd,
                                                 wr_op_e op);
    case (op)
      OP_PLAIN: return wd;
      OP_CLR:   return old & ~wd;
      OP_SET:   return old | wd;
      default:  return old;
    endcase
  endfunction

endpackage

// File: rtl/vpic_flag.sv
module vpic_flag #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pol_i,     // 1: active high / rising, 0: active low / falling
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic flag_o
);

  logic prev_q, flag_q;
  logic active, edge_hit, hw_set, flag_d;

  assign active   = pol_i ? req_i : ~req_i;
  // edge taken from the raw pin so a polarity change alone never fires
  assign edge_hit = pol_i ? (req_i & ~prev_q) : (~req_i & prev_q);
  assign hw_set   = LEVEL ? active : edge_hit;
  // hardware set wins over a software clear in the same cycle
  assign flag_d   = hw_set | (sw_we_i ? sw_val_i : flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  a_r3_edge_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!LEVEL && edge_hit) |=> flag_q);

  a_r4_level_clear_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL && active) |=> flag_q);

  a_r3_edge_no_self_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!LEVEL && !edge_hit && !flag_q && !sw_we_i) |=> !flag_q);

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int N_SRC = 64,
  parameter int VW    = $clog2(N_SRC)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_SRC-1:0]                     elig_i,
  input  logic [N_SRC-1:0][vpic_pkg::PRI_W-1:0] pri_i,
  output logic                                 valid_o,
  output logic [VW-1:0]                        vec_o,
  output logic [vpic_pkg::PRI_W-1:0]           pri_o
);
  import vpic_pkg::*;

  logic              found;
  logic [PRI_W-1:0]  best;
  logic [VW-1:0]     bidx;
  logic              valid_q;
  logic [VW-1:0]     vec_q;
  logic [PRI_W-1:0]  pri_q;

  // descending scan with >= lets the lower number take ties
  always_comb begin
    found = 1'b0;
    best  = '0;
    bidx  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (pri_i[i][4:2] != 3'd0) && (!found || pri_i[i] >= best)) begin
        found = 1'b1;
        best  = pri_i[i];
        bidx  = VW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      pri_q   <= '0;
    end else begin
      valid_q <= found;
      vec_q   <= bidx;
      pri_q   <= best;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;
  assign pri_o   = pri_q;

  a_r7_major_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (pri_q[4:2] != 3'd0));

  a_r8_idle_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (pri_q == '0 && vec_q == '0));

  a_r7_winner_was_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(elig_i) && valid_q |-> elig_i[vec_q]);

endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
  parameter int               N_SRC      = 64,
  parameter int               N_EXT      = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 64'hFFFF_FFFF_0000_0000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_we_i,
  input  logic [11:0]            bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  input  logic [N_SRC-N_EXT-1:0] src_i,
  input  logic [N_EXT-1:0]       ext_i,
  output logic                   irq_o,
  output logic [7:0]             vec_o
);
  import vpic_pkg::*;

  localparam int NW = N_SRC / 32;
  localparam int NP = N_SRC / 4;
  localparam int VW = $clog2(N_SRC);

  wr_op_e                        op;
  logic [7:0]                    slot, f_off, e_off, p_off;
  logic [11:0]                   v_off;
  logic                          hit_ctl, hit_stat, hit_flag, hit_en, hit_pri, hit_vofs;
  logic [VW-1:0]                 v_idx;

  logic [N_EXT-1:0]              pol_q;
  logic [N_SRC-1:0]              en_q;
  logic [N_SRC-1:0][PRI_W-1:0]   prio_q;
  logic [31:0]                   vofs_q [N_SRC];
  logic [N_SRC-1:0]              flag_w;
  logic [N_SRC-1:0]              elig;

  logic [31:0]                   flag_sel, en_sel, prio_sel, ctl_rd, status;
  logic [31:0]                   flag_new, en_new;
  logic [3:0][PRI_W-1:0]         prio_new;
  logic [N_EXT-1:0]              pol_new;
  logic [N_SRC-1:0]              flag_sw_we, flag_sw_val;

  logic                          sel_valid;
  logic [VW-1:0]                 sel_vec;
  logic [PRI_W-1:0]              sel_pri;

  // ---------------- address decode
  assign op       = wr_op_e'(bus_addr_i[3:2]);
  assign slot     = bus_addr_i[11:4];
  assign f_off    = slot - SLOT_FLAG;
  assign e_off    = slot - SLOT_EN;
  assign p_off    = slot - SLOT_PRI;
  assign v_off    = bus_addr_i - VOFS_BASE;
  assign hit_ctl  = (slot == SLOT_CTL);
  assign hit_stat = (slot == SLOT_STAT);
  assign hit_flag = (slot >= SLOT_FLAG) && (f_off < 8'(NW));
  assign hit_en   = (slot >= SLOT_EN)   && (e_off < 8'(NW));
  assign hit_pri  = (slot >= SLOT_PRI)  && (p_off < 8'(NP));
  assign hit_vofs = (bus_addr_i >= VOFS_BASE) && (v_off < 12'(4 * N_SRC)) && (v_off[1:0] == 2'b00);
  assign v_idx    = v_off[VW+1:2];

  // ---------------- addressed word views
  always_comb begin
    flag_sel = '0;
    en_sel   = '0;
    prio_sel = '0;
    for (int w = 0; w < NW; w++) begin
      if (f_off == 8'(w)) flag_sel = flag_w[32*w +: 32];
      if (e_off == 8'(w)) en_sel   = en_q[32*w +: 32];
    end
    for (int n = 0; n < NP; n++) begin
      if (p_off == 8'(n)) begin
        for (int l = 0; l < 4; l++) prio_sel[8*l +: PRI_W] = prio_q[4*n+l];
      end
    end
  end

  assign ctl_rd   = 32'(pol_q) << 1;
  assign status   = {19'b0, sel_pri, 8'(sel_vec)};
  assign flag_new = apply_op(flag_sel, bus_wdata_i, op);
  assign en_new   = apply_op(en_sel, bus_wdata_i, op);

  always_comb begin
    for (int l = 0; l < 4; l++)
      prio_new[l] = apply_pri(prio_sel[8*l +: PRI_W], bus_wdata_i[8*l +: PRI_W], op);
  end

  always_comb begin
    case (op)
      OP_PLAIN: pol_new = bus_wdata_i[N_EXT:1];
      OP_CLR:   pol_new = pol_q & ~bus_wdata_i[N_EXT:1];
      OP_SET:   pol_new = pol_q | bus_wdata_i[N_EXT:1];
      default:  pol_new = pol_q;
    endcase
  end

  // ---------------- flag write strobes
  always_comb begin
    flag_sw_we  = '0;
    flag_sw_val = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_we_i && hit_flag && f_off == 8'(w)) begin
        flag_sw_we[32*w +: 32]  = '1;
        flag_sw_val[32*w +: 32] = flag_new;
      end
    end
  end

  // ---------------- configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      en_q   <= '0;
      prio_q <= '0;
      for (int k = 0; k < N_SRC; k++) vofs_q[k] <= '0;
    end else if (bus_we_i) begin
      if (hit_ctl) pol_q <= pol_new;
      for (int w = 0; w < NW; w++)
        if (hit_en && e_off == 8'(w)) en_q[32*w +: 32] <= en_new;
      for (int n = 0; n < NP; n++)
        if (hit_pri && p_off == 8'(n))
          for (int l = 0; l < 4; l++) prio_q[4*n+l] <= prio_new[l];
      if (hit_vofs) vofs_q[v_idx] <= bus_wdata_i;
    end
  end

  // ---------------- per-source flags
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    if (k < N_EXT) begin : g_ext
      vpic_flag #(.LEVEL(1'b0)) i_flag (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (ext_i[k]),
        .pol_i    (pol_q[k]),
        .sw_we_i  (flag_sw_we[k]),
        .sw_val_i (flag_sw_val[k]),
        .flag_o   (flag_w[k])
      );
    end else begin : g_int
      vpic_flag #(.LEVEL(LEVEL_MASK[k])) i_flag (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (src_i[k-N_EXT]),
        .pol_i    (1'b1),
        .sw_we_i  (flag_sw_we[k]),
        .sw_val_i (flag_sw_val[k]),
        .flag_o   (flag_w[k])
      );
    end
  end

  assign elig = flag_w & en_q;

  vpic_arb #(.N_SRC(N_SRC), .VW(VW)) i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig),
    .pri_i   (prio_q),
    .valid_o (sel_valid),
    .vec_o   (sel_vec),
    .pri_o   (sel_pri)
  );

  assign irq_o = sel_valid;
  assign vec_o = 8'(sel_vec);

  // ---------------- read mux
  always_comb begin
    bus_rdata_o = '0;
    if (hit_ctl)       bus_rdata_o = ctl_rd;
    else if (hit_stat) bus_rdata_o = status;
    else if (hit_flag) bus_rdata_o = flag_sel;
    else if (hit_en)   bus_rdata_o = en_sel;
    else if (hit_pri)  bus_rdata_o = prio_sel;
    else if (hit_vofs) bus_rdata_o = vofs_q[v_idx];
  end

  a_r9_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $stable(en_q) |-> en_q[sel_vec]);

  a_r8_irq_has_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sel_pri != '0));

  a_r2_set_alias_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit_en && op == OP_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

// File: tb/test_vpic_top.sv
module test_vpic_top;
  localparam int  N_SRC  = 64;
  localparam int  N_EXT  = 4;
  localparam time CLK_PD = 10ns;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   we = 1'b0;
  logic [11:0]            addr = '0;
  logic [31:0]            wdata = '0;
  logic [31:0]            rdata;
  logic [N_SRC-N_EXT-1:0] src = '0;
  logic [N_EXT-1:0]       ext = '0;
  logic                   irq;
  logic [7:0]             vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PD/2) clk = ~clk;

  vpic_top #(.N_SRC(N_SRC), .N_EXT(N_EXT)) i_vpic_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src), .ext_i(ext),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); chk("R1 control", d, 0);
    rd(12'h020, d); chk("R1 status", d, 0);
    rd(12'h040, d); chk("R1 flag0", d, 0);
    rd(12'h0C0, d); chk("R1 enable0", d, 0);
    rd(12'h140, d); chk("R1 prio0", d, 0);
    rd(12'h540, d); chk("R1 vofs0", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(12'h0D0, 32'h00F0_00F0);
    wr(12'h0D8, 32'h0000_0001);
    wr(12'h0D4, 32'h0000_0010);
    rd(12'h0D0, d); chk("R2 set/clr alias", d, 32'h00F0_00E1);
    wr(12'h0D0, 32'h0);
    rd(12'h0D0, d); chk("R2 plain replace", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h150, 32'hFFFF_FFFF);
    rd(12'h150, d); chk("R6 lane width", d, 32'h1F1F_1F1F);
    wr(12'h150, 32'h0);
    wr(12'h158, 32'h0000_0300);
    rd(12'h150, d); chk("R6 lane1 set", d, 32'h0000_0300);
    wr(12'h150, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); src[1] = 1'b1;   // source 5
    cyc(2);
    rd(12'h040, d); chk("R3 edge captured", d, 32'h20);
    chk("R9 disabled not selected", 32'(irq), 0);
    wr(12'h044, 32'h20);
    cyc(2);
    rd(12'h040, d); chk("R3 held high no reset", d, 0);
    src[1] = 1'b0;
    cyc(2);
    rd(12'h040, d); chk("R3 falling ignored", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); src[36] = 1'b1;  // source 40, word1 bit8
    cyc(2);
    rd(12'h050, d); chk("R4 level set", d, 32'h100);
    wr(12'h054, 32'h100);
    cyc(1);
    rd(12'h050, d); chk("R4 clear blocked", d, 32'h100);
    src[36] = 1'b0;
    cyc(2);
    rd(12'h050, d); chk("R4 held after drop", d, 32'h100);
    wr(12'h054, 32'h100);
    rd(12'h050, d); chk("R4 clear after drop", d, 0);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    @(negedge clk); ext[2] = 1'b1;
    cyc(2);
    rd(12'h040, d); chk("R5 rising ignored falling mode", d, 0);
    ext[2] = 1'b0;
    cyc(2);
    rd(12'h040, d); chk("R5 falling flagged", d, 32'h4);
    wr(12'h044, 32'h4);
    wr(12'h008, 32'h8);
    rd(12'h000, d); chk("R5 polarity bit", d, 32'h8);
    rd(12'h040, d); chk("R5 pol change no flag", d, 0);
    @(negedge clk); ext[2] = 1'b1;
    cyc(2);
    rd(12'h040, d); chk("R5 rising flagged", d, 32'h4);
    wr(12'h044, 32'h4);
    ext[2] = 1'b0;
    cyc(2);
    rd(12'h040, d); chk("R5 falling ignored rising mode", d, 0);
    wr(12'h004, 32'h8);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(12'h150, 32'h0003_0908);   // src4 2/0, src5 2/1, src6 0/3
    wr(12'h0C8, 32'h70);
    @(negedge clk); src[2:0] = 3'b111;
    @(negedge clk); src[2:0] = 3'b000;
    cyc(1);
    rd(12'h020, d); chk("R7 sub-level wins", d, 32'h0905);
    chk("R8 irq", 32'(irq), 1);
    chk("R8 vec port", 32'(vec), 5);
    wr(12'h150, 32'h0003_0909);
    cyc(1);
    rd(12'h020, d); chk("R7 tie lowest number", d, 32'h0904);
    wr(12'h044, 32'h30);
    cyc(1);
    rd(12'h020, d); chk("R7 major zero ignored", d, 0);
    chk("R8 irq idle", 32'(irq), 0);
    wr(12'h1E0, 32'h1C);
    wr(12'h0D8, 32'h100);
    @(negedge clk); src[36] = 1'b1;
    @(negedge clk);
    chk("R8 one-cycle latency", 32'(irq), 0);
    @(negedge clk);
    rd(12'h020, d); chk("R8 level winner", d, 32'h1C28);
    wr(12'h054, 32'h100);
    cyc(1);
    chk("R4 irq held", 32'(irq), 1);
    src[36] = 1'b0;
    wr(12'h054, 32'h100);
    cyc(1);
    chk("R8 irq drop", 32'(irq), 0);
  endtask

  task automatic t_vofs();
    logic [31:0] d;
    wr(12'h568, 32'hDEAD_0010);
    rd(12'h568, d); chk("R10 offset word", d, 32'hDEAD_0010);
    rd(12'h564, d); chk("R10 neighbour", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_prio();
    t_edge();
    t_level();
    t_ext();
    t_arb();
    t_vofs();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule